// File: doc/BRIEF.md
# Two-Key Register Write Unlock

This block guards a peripheral's register file against stray bus writes. After reset every register behind it is write-protected: the block sees each bus write and passes a write strobe on to the protected registers only while it is in the open state. To open it, software writes a first 32-bit key to one kick address and then a second 32-bit key to a second kick address, in that order. The current state appears as one bit in a status word that the general control register merges into its read value.

The sequence checker has three states: idle, armed (first key seen) and open. A wrong value at either kick address, or the second key arriving while idle, sends a locked checker back to idle. Bus writes to other addresses during the sequence are dropped but do not break it. Once open, the block stays open until a value other than the first key is written to the first kick address. That write locks it again. Writes to the kick addresses themselves are never forwarded to the protected registers.

Top module: `regkey_unlock_gate`

## Requirements
- R1: While reset is asserted (synchronous, active low) and after it is released, the block is locked: `ctl_status` bit 23 reads 0 and `prot_we` stays low.
- R2: A write of 0x83E70B13 to offset 0x70 arms the checker. A following write of 0x95A4F1E0 to offset 0x74 opens the block, and `ctl_status` bit 23 reads 1 from the next clock cycle.
- R3: Writing the second key (0x95A4F1E0 to 0x74) while idle does not open the block and leaves the checker idle, so a later first key must precede a second key.
- R4: While locked, a value other than 0x83E70B13 written to 0x70, or a value other than 0x95A4F1E0 written to 0x74, returns the checker to idle. The full sequence is then needed again.
- R5: While locked, a bus write to any address is not forwarded (`prot_we` low).
- R6: While open, a bus write to any address other than 0x70 and 0x74 raises `prot_we` in the same cycle.
- R7: A bus write to 0x70 or 0x74 never raises `prot_we`, whether the block is locked or open.
- R8: While open, writing 0x83E70B13 to 0x70 or any value to 0x74 leaves the block open, so the sequence need not be repeated.
- R9: While open, a value other than 0x83E70B13 written to 0x70 locks the block from the next cycle, and the checker is idle.
- R10: While armed, bus writes to addresses other than 0x70 and 0x74 leave the checker armed.
- R11: All bits of `ctl_status` other than bit 23 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Bus write strobe for the current cycle |
| bus_addr | input | 12 | Byte offset of the bus write |
| bus_wdata | input | 32 | Bus write data |
| prot_we | output | 1 | Write strobe forwarded to the protected registers |
| ctl_status | output | 32 | Lock status bits merged into the general control register read (bit 23 = open) |

## Verification
The bench targets the transitions that a careless checker gets wrong. It sends the second key first, which a design that only looked for both keys would accept and open on. It sends a wrong value after the first key, which a design that kept the armed state would accept and open on. It writes unrelated registers between the two keys, which a design that reset on any write would reject, leaving the block locked. It also writes the second kick address while open, where a design that treated this as a mismatch would relock. It writes a non-key value to the first kick address while open, where a design that ignored kick writes once open could never be locked again. Throughout, it checks that kick writes never leak through as protected writes and that a protected write passes in the same cycle only once the block is open.

// File: rtl/regkey_unlock_pkg.sv
// Shared types for the two-key write unlock gate.
// Assumes: one bus write per clock at most; byte offsets on the address bus.
package regkey_unlock_pkg;

    // Sequence checker states.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_OPEN  = 2'd2
    } seq_state_e;

    // Classification of one bus write against the two kick addresses.
    typedef struct packed {
        logic first_key;    // first kick address, matching key
        logic first_other;  // first kick address, any other value
        logic second_key;   // second kick address, matching key
        logic second_other; // second kick address, any other value
    } kick_hit_t;

endpackage

// File: rtl/kick_decoder.sv
// Classifies each bus write against the two kick addresses and their keys.
// Assumes: addresses and keys are compile-time constants; purely combinational.
module kick_decoder
    import regkey_unlock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] FIRST_OFS  = 'h70,
    parameter logic [ADDR_W-1:0] SECOND_OFS = 'h74,
    parameter logic [DATA_W-1:0] FIRST_KEY  = 'h83E70B13,
    parameter logic [DATA_W-1:0] SECOND_KEY = 'h95A4F1E0
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output kick_hit_t         hit,
    output logic              any_kick
);

    logic at_first;
    logic at_second;

    // Address match for each kick register.
    always_comb begin
        at_first  = we && (addr == FIRST_OFS);
        at_second = we && (addr == SECOND_OFS);
    end

    // Split each kick write into key match or mismatch.
    always_comb begin
        hit.first_key    = at_first  && (wdata == FIRST_KEY);
        hit.first_other  = at_first  && (wdata != FIRST_KEY);
        hit.second_key   = at_second && (wdata == SECOND_KEY);
        hit.second_other = at_second && (wdata != SECOND_KEY);
        any_kick         = at_first || at_second;
    end

endmodule

// File: rtl/unlock_seq.sv
// Holds the lock state and walks the two-key sequence.
// Assumes: kick hits are mutually exclusive; synchronous active-low reset.
module unlock_seq
    import regkey_unlock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  kick_hit_t hit,
    output logic      is_open
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next-state selection from the current state and this cycle's kick write.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (hit.first_key) state_d = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (hit.second_key)
                    state_d = SEQ_OPEN;
                else if (hit.first_other || hit.second_other)
                    state_d = SEQ_IDLE;
            end
            SEQ_OPEN: begin
                if (hit.first_other) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register; reset leaves the block locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Open flag seen by the write gate and status word.
    always_comb is_open = (state_q == SEQ_OPEN);

endmodule

// File: rtl/wr_gate.sv
// Passes bus writes to the protected registers only while open, never kick writes.
// Assumes: the open flag is registered, so the gate adds no loop.
module wr_gate (
    input  logic we,
    input  logic is_kick,
    input  logic is_open,
    output logic prot_we
);

    // Forward the strobe only for non-kick writes while open.
    always_comb prot_we = we && is_open && !is_kick;

endmodule

// File: rtl/regkey_unlock_gate.sv
// Top of the two-key write unlock gate: decoder, sequence checker, write gate
// and the status word merged into the general control register read.
// Assumes: the protected registers sit outside and use prot_we as their strobe.
module regkey_unlock_gate
    import regkey_unlock_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int OPEN_BIT   = 23,
    parameter logic [ADDR_W-1:0] FIRST_OFS  = 'h70,
    parameter logic [ADDR_W-1:0] SECOND_OFS = 'h74,
    parameter logic [DATA_W-1:0] FIRST_KEY  = 'h83E70B13,
    parameter logic [DATA_W-1:0] SECOND_KEY = 'h95A4F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              prot_we,
    output logic [DATA_W-1:0] ctl_status
);

    kick_hit_t hit;
    logic      any_kick;
    logic      is_open;

    kick_decoder #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FIRST_OFS(FIRST_OFS), .SECOND_OFS(SECOND_OFS),
        .FIRST_KEY(FIRST_KEY), .SECOND_KEY(SECOND_KEY)
    ) u_dec (
        .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .hit(hit), .any_kick(any_kick)
    );

    unlock_seq u_seq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .is_open(is_open)
    );

    wr_gate u_gate (
        .we(bus_we), .is_kick(any_kick), .is_open(is_open), .prot_we(prot_we)
    );

    // Status word: only the open bit is driven, the rest read zero.
    always_comb begin
        ctl_status           = '0;
        ctl_status[OPEN_BIT] = is_open;
    end

endmodule

// File: rtl/regkey_unlock_chk.sv
// Property checker for the two-key write unlock gate, bound to the top.
module regkey_unlock_chk #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int OPEN_BIT = 23,
    parameter logic [ADDR_W-1:0] FIRST_OFS  = 'h70,
    parameter logic [ADDR_W-1:0] SECOND_OFS = 'h74,
    parameter logic [DATA_W-1:0] FIRST_KEY  = 'h83E70B13,
    parameter logic [DATA_W-1:0] SECOND_KEY = 'h95A4F1E0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              prot_we,
    input logic [DATA_W-1:0] ctl_status
);

    logic open_s;
    logic kick_w;
    always_comb begin
        open_s = ctl_status[OPEN_BIT];
        kick_w = bus_we && (bus_addr == FIRST_OFS || bus_addr == SECOND_OFS);
    end

    // R1
    reset_locks_chk: assert property (@(posedge clk) !rst_n |=> !open_s);

    // R2
    open_needs_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_s) |-> $past(bus_we && bus_addr == SECOND_OFS && bus_wdata == SECOND_KEY));

    // R5
    locked_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_we |-> open_s);

    // R7
    kick_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_w |-> !prot_we);

    // R8
    open_second_kick_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_s && bus_we && bus_addr == SECOND_OFS) |=> open_s);

    // R9
    relock_on_bad_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == FIRST_OFS && bus_wdata != FIRST_KEY) |=> !open_s);

    // R11
    status_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctl_status) == (open_s ? 1 : 0));

endmodule

bind regkey_unlock_gate regkey_unlock_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPEN_BIT(OPEN_BIT),
    .FIRST_OFS(FIRST_OFS), .SECOND_OFS(SECOND_OFS),
    .FIRST_KEY(FIRST_KEY), .SECOND_KEY(SECOND_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .prot_we(prot_we), .ctl_status(ctl_status)
);

// File: tb/tb_regkey_unlock_gate.sv
// Scoreboard bench: the driver pushes expected strobe and lock state per cycle,
// the monitor pops and compares a quarter period after each falling edge.
module tb_regkey_unlock_gate;

    localparam int PERIOD = 10;
    localparam logic [11:0] A1 = 12'h070;
    localparam logic [11:0] A2 = 12'h074;
    localparam logic [31:0] K1 = 32'h83E70B13;
    localparam logic [31:0] K2 = 32'h95A4F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        prot_we;
    logic [31:0] ctl_status;

    int checks = 0;
    int fails  = 0;
    int mstate = 0; // 0 idle, 1 armed, 2 open

    logic  q_we[$];
    logic  q_open[$];
    string q_tag[$];

    regkey_unlock_gate dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .prot_we(prot_we), .ctl_status(ctl_status)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one bus cycle, expected values from the reference model.
    task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input string tag);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        q_we.push_back(we && mstate == 2 && a != A1 && a != A2);
        q_open.push_back(mstate == 2);
        q_tag.push_back(tag);
        if (we) begin
            case (mstate)
                0: if (a == A1 && d == K1) mstate = 1;
                1: begin
                    if (a == A1)      mstate = (d == K1) ? 1 : 0;
                    else if (a == A2) mstate = (d == K2) ? 2 : 0;
                end
                default: if (a == A1 && d != K1) mstate = 0;
            endcase
        end
    endtask

    // Monitor: compare outputs against the queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            if (q_we.size() > 0) begin
                logic  ew;
                logic  eo;
                string tg;
                ew = q_we.pop_front();
                eo = q_open.pop_front();
                tg = q_tag.pop_front();
                check(prot_we === ew, tg, "prot_we", {31'b0, prot_we}, {31'b0, ew});
                check(ctl_status[23] === eo, tg, "open bit", {31'b0, ctl_status[23]}, {31'b0, eo});
                check((ctl_status & ~32'h0080_0000) == 32'h0, "R11", "spare status bits",
                      ctl_status, 32'h0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: locked during reset even with a write driven
        bus_we = 1'b1; bus_addr = 12'h010; bus_wdata = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk); #(PERIOD/4);
        check(prot_we === 1'b0, "R1", "prot_we in reset", {31'b0, prot_we}, 32'h0);
        check(ctl_status === 32'h0, "R1", "status in reset", ctl_status, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; bus_we = 1'b0;

        cyc(0, 12'h000, 0,          "R1_after_reset");
        cyc(1, 12'h010, 32'h1234,   "R5_locked_write");
        cyc(1, A2,      K2,         "R3_second_first");
        cyc(1, 12'h010, 32'h5,      "R3_still_locked");
        cyc(1, A1,      K1,         "R2_first_key");
        cyc(1, A2,      32'hDEAD,   "R4_bad_second");
        cyc(1, A2,      K2,         "R4_after_bad_second");
        cyc(0, 12'h000, 0,          "R4_locked");
        cyc(1, A1,      K1,         "R4_first_key");
        cyc(1, A1,      32'h1,      "R4_bad_first");
        cyc(1, A2,      K2,         "R4_after_bad_first");
        cyc(0, 12'h000, 0,          "R4_locked2");
        cyc(1, A1,      K1,         "R10_first_key");
        cyc(1, 12'h020, 32'hAA,     "R10_other_write");
        cyc(1, A2,      K2,         "R2_second_key");
        cyc(0, 12'h000, 0,          "R2_open");
        cyc(1, 12'h020, 32'hBB,     "R6_forward");
        cyc(1, 12'h000, 32'hCC,     "R6_forward_low");
        cyc(1, A2,      32'h0,      "R7_kick2_open");
        cyc(1, A1,      K1,         "R8_first_key_again");
        cyc(1, A2,      K2,         "R8_second_again");
        cyc(1, 12'h040, 32'h1,      "R8_still_open");
        cyc(1, A1,      32'h0,      "R9_relock");
        cyc(1, 12'h040, 32'h2,      "R9_locked_drop");
        cyc(1, A2,      K2,         "R9_idle_after_relock");
        cyc(1, 12'h040, 32'h3,      "R9_still_locked");
        cyc(0, 12'h000, 0,          "R7_end");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule